// File: doc/BRIEF.md
# Multi-Port Write Collision Filter

This block sits between four write requesters and a multi-ported storage array. In each clock cycle it looks at all four write requests. When two or more enabled ports aim at the same address, it lets exactly one of them through. The storage therefore never sees two writes to one location in the same cycle, which would leave that location undefined. Addresses and data pass through unchanged. Only the write enables are gated, so the storage can consume the outputs directly in the same cycle.

The port that wins a contested address is chosen by a build-time mode:

- **Fixed mode:** the lowest port index always wins.
- **Round-robin mode:** a one-hot marker register sets where the search starts. The search scans upward from the marked port, wrapping past the top, and the first contender found wins. The marker steps forward by one only when the marked port itself wins a contested write.

Write data plays no part in the decision. Each suppressed port gets a collision flag in the same cycle.

Top module: `wr_collision_filter`

## Requirements
- R1: The output address and data buses equal the input address and data buses in the same cycle, for every port.
- R2: In any cycle, no two asserted output enables carry the same address.
- R3: An enabled port whose address is not shared by any other enabled port always has its output enable asserted.
- R4: A port whose input enable is low has output enable and collision flag low, and never blocks another port, even when its address matches.
- R5: In fixed mode, within each group of enabled ports sharing an address, only the lowest-numbered port is granted.
- R6: Data values are never compared: ports with identical data on a shared address still collide, and only one is granted.
- R7: A port's collision flag is high in exactly the cycles where its input enable is high and its output enable is low, with no added latency.
- R8: In round-robin mode, the winner of each group is the first group member met when scanning port indices upward from the marked port, wrapping from 3 to 0.
- R9: The round-robin marker selects port 0 after reset. It advances by one position (3 wraps to 0) at a clock edge only if the marked port won a contested write in that cycle; otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | NUM_PORTS | Write request per port |
| wr_addr | input | NUM_PORTS*ADDR_W | Write addresses, port k at bits [k*ADDR_W +: ADDR_W] |
| wr_data | input | NUM_PORTS*DATA_W | Write data, port k at bits [k*DATA_W +: DATA_W] |
| out_en | output | NUM_PORTS | Gated write enables toward storage |
| out_addr | output | NUM_PORTS*ADDR_W | Pass-through addresses |
| out_data | output | NUM_PORTS*DATA_W | Pass-through data |
| collide | output | NUM_PORTS | Port was suppressed this cycle |

## Verification
The bench targets these corner cases:

- **All four ports on one address.** An arbiter that only resolves pairs would grant two ports here.
- **A disabled port sharing an address with an enabled one.** A comparator that ignores the enables would wrongly suppress the live port.
- **Two separate collision groups in one cycle.** This exposes a design that resolves only one group per cycle.
- **Equal data on a shared address.** A design that compares data would let both writes through.

In round-robin mode, the bench checks several things:

- Repeated full collisions, which should walk the marker through every port.
- Idle cycles and cycles without collisions, which must not move the marker.
- A marked port 3 facing a group of ports 1 and 2. A scan without wraparound would pick port 2 instead of port 1.

// File: rtl/wcf_pkg.sv
package wcf_pkg;

  typedef enum logic {
    PRIO_FIXED = 1'b0,
    PRIO_ROUND = 1'b1
  } prio_mode_e;

  // Distance of a port from the search origin; smaller wins.
  function automatic int prio_rank(input int port, input int origin, input int n);
    return (port + n - origin) % n;
  endfunction

endpackage

// File: rtl/wcf_addr_match.sv
module wcf_addr_match #(
  parameter int NP = 4,
  parameter int AW = 8
) (
  input  logic [NP-1:0]    en,
  input  logic [NP*AW-1:0] addr,
  output logic [NP*NP-1:0] match
);
  for (genvar i = 0; i < NP; i++) begin : g_row
    for (genvar j = 0; j < NP; j++) begin : g_col
      if (i == j) begin : g_self
        assign match[i*NP+j] = 1'b0;
      end else begin : g_pair
        assign match[i*NP+j] = en[i] & en[j] &
                               (addr[i*AW +: AW] == addr[j*AW +: AW]);
      end
    end
  end
endmodule

// File: rtl/wcf_grant.sv
module wcf_grant #(
  parameter int NP = 4,
  parameter wcf_pkg::prio_mode_e MODE = wcf_pkg::PRIO_ROUND
) (
  input  logic [NP-1:0]    en,
  input  logic [NP*NP-1:0] match,
  input  logic [NP-1:0]    ptr,
  output logic [NP-1:0]    grant,
  output logic [NP-1:0]    lost
);
  int origin;

  always_comb begin
    origin = 0;
    if (MODE == wcf_pkg::PRIO_ROUND) begin
      for (int k = 0; k < NP; k++) begin
        if (ptr[k]) origin = k;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      lost[i] = 1'b0;
      for (int j = 0; j < NP; j++) begin
        if (match[i*NP+j] &&
            (wcf_pkg::prio_rank(j, origin, NP) < wcf_pkg::prio_rank(i, origin, NP)))
          lost[i] = 1'b1;
      end
    end
    grant = en & ~lost;
  end
endmodule

// File: rtl/wcf_rr_ptr.sv
module wcf_rr_ptr #(
  parameter int NP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  output logic [NP-1:0] ptr
);
  localparam logic [NP-1:0] PTR_INIT = NP'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= PTR_INIT;
    else if (advance) ptr <= {ptr[NP-2:0], ptr[NP-1]};
  end
endmodule

// File: rtl/wr_collision_filter.sv
module wr_collision_filter #(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter wcf_pkg::prio_mode_e MODE = wcf_pkg::PRIO_ROUND
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS-1:0]        wr_en,
  input  logic [NUM_PORTS*ADDR_W-1:0] wr_addr,
  input  logic [NUM_PORTS*DATA_W-1:0] wr_data,
  output logic [NUM_PORTS-1:0]        out_en,
  output logic [NUM_PORTS*ADDR_W-1:0] out_addr,
  output logic [NUM_PORTS*DATA_W-1:0] out_data,
  output logic [NUM_PORTS-1:0]        collide
);
  localparam int NP = NUM_PORTS;

  logic [NP*NP-1:0] match;
  logic [NP-1:0]    contested;
  logic [NP-1:0]    grant;
  logic [NP-1:0]    lost;
  logic [NP-1:0]    rr_ptr;
  logic             rr_advance;

  wcf_addr_match #(.NP(NP), .AW(ADDR_W)) u_match (
    .en(wr_en), .addr(wr_addr), .match(match)
  );

  for (genvar i = 0; i < NP; i++) begin : g_cont
    assign contested[i] = |match[i*NP +: NP];
  end

  wcf_grant #(.NP(NP), .MODE(MODE)) u_grant (
    .en(wr_en), .match(match), .ptr(rr_ptr), .grant(grant), .lost(lost)
  );

  assign rr_advance = |(rr_ptr & grant & contested);

  if (MODE == wcf_pkg::PRIO_ROUND) begin : g_rr
    wcf_rr_ptr #(.NP(NP)) u_ptr (
      .clk(clk), .rst_n(rst_n), .advance(rr_advance), .ptr(rr_ptr)
    );
  end else begin : g_fixed
    assign rr_ptr = NP'(1);
  end

  assign out_en   = grant;
  assign collide  = wr_en & lost;
  assign out_addr = wr_addr;
  assign out_data = wr_data;
endmodule

// File: rtl/wcf_checker.sv
module wcf_checker #(
  parameter int NP = 4,
  parameter int AW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NP-1:0]    wr_en,
  input logic [NP*AW-1:0] wr_addr,
  input logic [NP-1:0]    out_en,
  input logic [NP-1:0]    collide,
  input logic [NP-1:0]    rr_ptr
);
  logic [NP-1:0] solo;
  logic [NP-1:0] has_win;

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      solo[i]    = wr_en[i];
      has_win[i] = 1'b0;
      for (int j = 0; j < NP; j++) begin
        if (j != i && wr_addr[i*AW +: AW] == wr_addr[j*AW +: AW]) begin
          if (wr_en[j])  solo[i]    = 1'b0;
          if (out_en[j]) has_win[i] = 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_port
    for (genvar j = i + 1; j < NP; j++) begin : g_pair
      assert_unique_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_en[i] && out_en[j] && wr_addr[i*AW +: AW] == wr_addr[j*AW +: AW]));
    end
    assert_solo_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      solo[i] |-> out_en[i]);
    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en[i] |-> (!out_en[i] && !collide[i]));
    assert_flag_loser_R7: assert property (@(posedge clk) disable iff (!rst_n)
      collide[i] |-> (wr_en[i] && !out_en[i] && has_win[i]));
  end

  assert_ptr_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rr_ptr) == 1);
  assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|collide) |=> $stable(rr_ptr));
endmodule

bind wr_collision_filter wcf_checker #(.NP(NUM_PORTS), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .out_en(out_en), .collide(collide), .rr_ptr(rr_ptr)
);

// File: tb/wr_collision_filter_test.sv
module wr_collision_filter_test;
  localparam int NP = 4;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]    wr_en = '0;
  logic [NP*AW-1:0] wr_addr = '0;
  logic [NP*DW-1:0] wr_data = '0;
  logic [NP-1:0]    rr_en, rr_col, fx_en, fx_col;
  logic [NP*AW-1:0] rr_addr, fx_addr;
  logic [NP*DW-1:0] rr_data, fx_data;

  int checks = 0;
  int errors = 0;
  int mptr = 0;

  always #2 clk = ~clk;

  wr_collision_filter #(.NUM_PORTS(NP), .ADDR_W(AW), .DATA_W(DW),
                        .MODE(wcf_pkg::PRIO_ROUND)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_en(rr_en), .out_addr(rr_addr), .out_data(rr_data), .collide(rr_col));

  wr_collision_filter #(.NUM_PORTS(NP), .ADDR_W(AW), .DATA_W(DW),
                        .MODE(wcf_pkg::PRIO_FIXED)) uut_fixed (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_en(fx_en), .out_addr(fx_addr), .out_data(fx_data), .collide(fx_col));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scan from origin; each enabled port is granted iff it is the first enabled
  // port of its address encountered.
  function automatic logic [NP-1:0] model_grant(input logic [NP-1:0] en,
                                                input logic [NP*AW-1:0] ad,
                                                input int origin);
    logic [NP-1:0] g = '0;
    for (int k = 0; k < NP; k++) begin
      int p = (origin + k) % NP;
      bit seen = 0;
      for (int m = 0; m < k; m++) begin
        int q = (origin + m) % NP;
        if (en[q] && ad[q*AW +: AW] == ad[p*AW +: AW]) seen = 1;
      end
      if (en[p] && !seen) g[p] = 1'b1;
    end
    return g;
  endfunction

  function automatic bit marked_contested(input logic [NP-1:0] en,
                                          input logic [NP*AW-1:0] ad, input int p);
    bit c = 0;
    for (int k = 0; k < NP; k++)
      if (k != p && en[k] && en[p] && ad[k*AW +: AW] == ad[p*AW +: AW]) c = 1;
    return c;
  endfunction

  task automatic step(input logic [NP-1:0] en, input logic [NP*AW-1:0] ad,
                      input logic [NP*DW-1:0] dt, input string tag);
    logic [NP-1:0] e_rr, e_fx;
    @(negedge clk);
    wr_en = en; wr_addr = ad; wr_data = dt;
    #1;
    e_rr = model_grant(en, ad, mptr);
    e_fx = model_grant(en, ad, 0);
    chk(rr_en == e_rr, {tag, " R8 rr grant"}, 64'(rr_en), 64'(e_rr));
    chk(rr_col == (en & ~e_rr), {tag, " R7 rr flag"}, 64'(rr_col), 64'(en & ~e_rr));
    chk(fx_en == e_fx, {tag, " R5 fixed grant"}, 64'(fx_en), 64'(e_fx));
    chk(fx_col == (en & ~e_fx), {tag, " R7 fixed flag"}, 64'(fx_col), 64'(en & ~e_fx));
    chk(rr_addr == ad && fx_addr == ad, {tag, " R1 addr"}, 64'(rr_addr), 64'(ad));
    chk(rr_data == dt && fx_data == dt, {tag, " R1 data"}, rr_data, dt);
    if (marked_contested(en, ad, mptr)) mptr = (mptr + 1) % NP;
  endtask

  function automatic logic [NP*AW-1:0] A(input int a0, a1, a2, a3);
    return {AW'(a3), AW'(a2), AW'(a1), AW'(a0)};
  endfunction

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    #1;
    chk(rr_en == 0 && fx_en == 0 && rr_col == 0, "reset R4 idle", 64'(rr_en), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // R9: after reset the marker is port 0: full collision, port 0 wins.
    step(4'b1111, A(7,7,7,7), 64'h1111_2222_3333_4444, "R9 reset marker");
    // R9: marker walks 1,2,3 then wraps to 0.
    for (int r = 0; r < 4; r++) step(4'b1111, A(9,9,9,9), 64'h0, "R9 rotate");
    // R3: distinct addresses all pass.
    step(4'b1111, A(1,2,3,4), 64'h5, "R3 distinct");
    // R9: idle cycles and no-collision cycles hold the marker.
    step(4'b0000, A(5,5,5,5), 64'h0, "R9 idle hold");
    step(4'b1111, A(3,3,3,3), 64'h0, "R9 after hold");
    // R6: identical data still collides.
    step(4'b0110, A(0,8,8,0), {4{16'hABCD}}, "R6 equal data");
    // R4: disabled port with matching address does not block.
    step(4'b0100, A(6,6,6,6), 64'h0, "R4 disabled match");
    step(4'b1010, A(4,4,9,4), 64'h0, "R4 partial");
    // two independent groups in one cycle
    step(4'b1111, A(2,5,2,5), 64'h0, "R2 two groups");
    // R8: walk marker to 3, then group {1,2} must pick 1 by wraparound.
    while (mptr != 3) step(4'b1111, A(1,1,1,1), 64'h0, "R9 walk");
    step(4'b0110, A(0,4,4,0), 64'h0, "R8 wrap");
    // random traffic with narrow address range
    for (int n = 0; n < 3000; n++) begin
      logic [NP*AW-1:0] ad;
      logic [NP*DW-1:0] dt;
      for (int k = 0; k < NP; k++) begin
        ad[k*AW +: AW] = AW'($urandom_range(0, 3));
        dt[k*DW +: DW] = DW'($urandom_range(0, 3));
      end
      step(NP'($urandom_range(0, 15)), ad, dt, "random R2 R3");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule